// File: doc/BRIEF.md
# PTP Timestamp Readiness Controller

This block decides, for one Ethernet port, when precision-time stamps can be trusted in each direction, and it gates traffic and timestamps to match. It watches three active-low resets (TX datapath, RX datapath and configuration), a link-up level, a one-cycle pulse for each received packet of any type, and a one-cycle pulse for a major time-of-day update. It drives a TX-ready flag, an RX-ready flag, a grant for time-stamped TX frames and a qualifier for RX timestamps.

RX readiness needs a deskew training phase: a set number of received packets must arrive with the link up. That count is cleared by the RX reset, the configuration reset and a link drop, but a TX-only reset leaves it in place. After a TX-side reset or a time-of-day update, a guard window measured in alignment-marker periods blocks time-stamped TX and marks RX timestamps invalid while the new time alignment settles. One alignment-marker period is 81,920 × 66 bit times of 97 ps, about 524.45 µs. Its length in clock cycles is a parameter (default 104,891 cycles of a 200 MHz clock). A TX frame that has already started under a grant runs to its end.

All inputs are sampled on the rising clock edge. All outputs come from registers. The configuration reset is the full reset of the block.

Top module: `ptp_ready_ctrl`

## Requirements
- R1: `tx_ready` is 1 after every rising edge at which both `tx_rst_n` and `cfg_rst_n` are 1, and 0 after any edge at which either is 0. `rx_rst_n` has no effect on `tx_ready` and does not start the guard window.
- R2: `rx_ready` is 0 after any edge at which `tx_rst_n`, `rx_rst_n` or `cfg_rst_n` is 0.
- R3: With no reset asserted and the link up, `rx_ready` goes to 1 at the edge that samples the TRAIN_PKTS-th `rx_pkt` pulse since training last restarted, and not before.
- R4: A reset on `tx_rst_n` alone keeps the training state. If the link stays up, `rx_ready` is 1 again after the first edge with all resets released, with no new packets.
- R5: At an edge with `link_up` at 0, `rx_ready` goes to 0 and the training count clears. `rx_pkt` pulses while the link is down are not counted, so TRAIN_PKTS new packets are needed once the link is back.
- R6: An edge with `tx_rst_n` or `cfg_rst_n` at 0, or with `tod_major` at 1, restarts the guard window. The window then lasts GUARD_AMS × AM_CYCLES further edges. While it runs, `rx_ts_valid` is 0 and no new TX grant is given.
- R7: `tx_grant` is 1 when `tx_ready` is 1 and the guard window has expired. It is 0 whenever `tx_ready` is 0.
- R8: If `tx_frame_active` is 1 at an edge where `tx_grant` is 1 and no TX-side reset is asserted, `tx_grant` stays 1 for as long as `tx_frame_active` stays 1, even if the guard window restarts. A frame that starts while `tx_grant` is 0 gets no grant.
- R9: `rx_ts_valid` is 1 exactly when `rx_ready` is 1 and the guard window has expired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| tx_rst_n | input | 1 | Active-low TX datapath reset |
| rx_rst_n | input | 1 | Active-low RX datapath reset |
| cfg_rst_n | input | 1 | Active-low configuration reset; full reset of the block |
| link_up | input | 1 | Ethernet link is up |
| rx_pkt | input | 1 | One-cycle pulse per received packet of any type |
| tod_major | input | 1 | One-cycle pulse on a major time-of-day update |
| tx_frame_active | input | 1 | High while a time-stamped TX frame is being sent |
| tx_ready | output | 1 | TX timestamping is out of reset |
| rx_ready | output | 1 | RX deskew complete and the RX path is usable |
| tx_grant | output | 1 | Time-stamped TX frames may be sent |
| rx_ts_valid | output | 1 | RX timestamps can be trusted |

## Verification
The stimulus first brings the block out of a full reset and feeds it training packets one at a time, so that the cycle where RX readiness rises pins down the threshold count. A lone RX reset, a lone TX reset and a link drop each follow. Only the first and last of these should require retraining, and only the TX reset should restart the guard window. Time-of-day updates are applied both with a frame in flight and with the port idle, which separates the hold of a started frame from the plain guard block. A frame that starts during the guard is also tried, to show that holding a frame is not the same as granting one. Packets sent while the link is down confirm that they do not count toward training.

// File: rtl/ptp_rdy_pkg.sv
package ptp_rdy_pkg;

   // Counter width able to hold values 0 .. n-1, never below one bit.
   function automatic int unsigned cnt_w(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Decoded view of the three port resets, high meaning "released".
   typedef struct packed {
      logic tx_ok;
      logic rx_ok;
      logic cfg_ok;
   } rst_view_t;

endpackage

// File: rtl/ptp_am_guard.sv
// Alignment-marker period divider plus a guard window measured in whole
// periods. A restart pulse reloads the window and realigns the divider.
module ptp_am_guard #(
   parameter int unsigned AM_CYCLES = 104891,
   parameter int unsigned GUARD_AMS = 2
) (
   input  logic clk,
   input  logic restart,
   output logic guard_clear
);
   import ptp_rdy_pkg::*;

   localparam int unsigned GW = cnt_w(GUARD_AMS + 1);

   logic [GW-1:0] guard_rem_q;
   logic          am_tick;
   logic          guard_run;

   assign guard_run = (guard_rem_q != '0);

   generate
      if (AM_CYCLES == 1) begin : g_unit_period
         // Every cycle is one period: no divider needed.
         assign am_tick = guard_run;
      end else begin : g_divider
         localparam int unsigned AW = cnt_w(AM_CYCLES);
         localparam logic [AW-1:0] AM_LAST = AW'(AM_CYCLES - 1);

         logic [AW-1:0] am_cnt_q;

         always_ff @(posedge clk) begin
            if (restart) begin
               am_cnt_q <= '0;
            end else if (guard_run) begin
               if (am_cnt_q == AM_LAST) begin
                  am_cnt_q <= '0;
               end else begin
                  am_cnt_q <= am_cnt_q + 1'b1;
               end
            end
         end

         assign am_tick = guard_run && (am_cnt_q == AM_LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (restart) begin
         guard_rem_q <= GW'(GUARD_AMS);
      end else if (am_tick) begin
         guard_rem_q <= guard_rem_q - 1'b1;
      end
   end

   assign guard_clear = ~guard_run;

endmodule

// File: rtl/ptp_rx_train.sv
// Counts received training packets until deskew is considered complete.
module ptp_rx_train #(
   parameter int unsigned TRAIN_PKTS = 20
) (
   input  logic clk,
   input  logic clear,
   input  logic pkt_seen,
   output logic deskew_q,
   output logic deskew_nxt
);
   import ptp_rdy_pkg::*;

   localparam int unsigned TW = cnt_w(TRAIN_PKTS + 1);
   localparam logic [TW-1:0] T_LAST = TW'(TRAIN_PKTS - 1);

   logic [TW-1:0] train_cnt_q;
   logic          done_q;
   logic          count_it;
   logic          reach;

   assign count_it   = pkt_seen & ~done_q;
   assign reach      = count_it && (train_cnt_q == T_LAST);
   assign deskew_nxt = clear ? 1'b0 : (done_q | reach);

   always_ff @(posedge clk) begin
      if (clear) begin
         train_cnt_q <= '0;
         done_q      <= 1'b0;
      end else begin
         if (count_it) begin
            train_cnt_q <= train_cnt_q + 1'b1;
         end
         if (reach) begin
            done_q <= 1'b1;
         end
      end
   end

   assign deskew_q = done_q;

endmodule

// File: rtl/ptp_tx_gate.sv
// TX readiness flag and frame-aware grant for time-stamped frames.
module ptp_tx_gate (
   input  logic clk,
   input  logic tx_side_ok,
   input  logic guard_clear,
   input  logic frame_active,
   output logic tx_ready,
   output logic tx_grant
);
   logic ready_q;
   logic in_flight_q;
   logic grant;

   assign grant = ready_q & (guard_clear | in_flight_q);

   always_ff @(posedge clk) begin
      ready_q     <= tx_side_ok;
      in_flight_q <= tx_side_ok & frame_active & grant;
   end

   assign tx_ready = ready_q;
   assign tx_grant = grant;

endmodule

// File: rtl/ptp_ready_ctrl.sv
module ptp_ready_ctrl #(
   parameter int unsigned TRAIN_PKTS = 20,
   // One alignment-marker period (~524.45 us) in 5 ns clock cycles, rounded up.
   parameter int unsigned AM_CYCLES  = 104891,
   parameter int unsigned GUARD_AMS  = 2
) (
   input  logic clk,
   input  logic tx_rst_n,
   input  logic rx_rst_n,
   input  logic cfg_rst_n,
   input  logic link_up,
   input  logic rx_pkt,
   input  logic tod_major,
   input  logic tx_frame_active,
   output logic tx_ready,
   output logic rx_ready,
   output logic tx_grant,
   output logic rx_ts_valid
);
   import ptp_rdy_pkg::*;

   generate
      if (TRAIN_PKTS < 1) begin : g_bad_train
         $error("TRAIN_PKTS must be at least 1");
      end
      if (AM_CYCLES < 1) begin : g_bad_am
         $error("AM_CYCLES must be at least 1");
      end
      if (GUARD_AMS < 1) begin : g_bad_guard
         $error("GUARD_AMS must be at least 1");
      end
   endgenerate

   rst_view_t rv;
   logic      tx_side_ok;
   logic      all_ok;
   logic      guard_restart;
   logic      guard_clear;
   logic      train_clear;
   logic      pkt_seen;
   logic      deskew_q;
   logic      deskew_nxt;
   logic      rx_ready_q;

   assign rv.tx_ok  = tx_rst_n;
   assign rv.rx_ok  = rx_rst_n;
   assign rv.cfg_ok = cfg_rst_n;

   assign tx_side_ok    = rv.tx_ok & rv.cfg_ok;
   assign all_ok        = tx_side_ok & rv.rx_ok;
   assign guard_restart = ~tx_side_ok | tod_major;
   assign train_clear   = ~rv.cfg_ok | ~rv.rx_ok | ~link_up;
   assign pkt_seen      = rx_pkt & link_up & all_ok;

   ptp_am_guard #(
      .AM_CYCLES (AM_CYCLES),
      .GUARD_AMS (GUARD_AMS)
   ) u_guard (
      .clk         (clk),
      .restart     (guard_restart),
      .guard_clear (guard_clear)
   );

   ptp_rx_train #(
      .TRAIN_PKTS (TRAIN_PKTS)
   ) u_train (
      .clk        (clk),
      .clear      (train_clear),
      .pkt_seen   (pkt_seen),
      .deskew_q   (deskew_q),
      .deskew_nxt (deskew_nxt)
   );

   ptp_tx_gate u_txg (
      .clk          (clk),
      .tx_side_ok   (tx_side_ok),
      .guard_clear  (guard_clear),
      .frame_active (tx_frame_active),
      .tx_ready     (tx_ready),
      .tx_grant     (tx_grant)
   );

   always_ff @(posedge clk) begin
      rx_ready_q <= all_ok & link_up & deskew_nxt;
   end

   assign rx_ready    = rx_ready_q;
   assign rx_ts_valid = rx_ready_q & guard_clear;

endmodule

// File: rtl/ptp_ready_ctrl_sva.sv
module ptp_ready_ctrl_sva (
   input logic clk,
   input logic tx_rst_n,
   input logic rx_rst_n,
   input logic cfg_rst_n,
   input logic link_up,
   input logic tod_major,
   input logic tx_frame_active,
   input logic tx_ready,
   input logic rx_ready,
   input logic tx_grant,
   input logic rx_ts_valid
);

   p_tx_reset_drop_r1: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      !tx_rst_n |=> !tx_ready);

   p_rx_reset_drop_r2: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      (!tx_rst_n || !rx_rst_n) |=> !rx_ready);

   p_link_drop_r5: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      !link_up |=> !rx_ready);

   p_tod_guard_r6: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      tod_major |=> !rx_ts_valid);

   p_release_guard_r6: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      $rose(tx_rst_n) |-> (!tx_grant && !rx_ts_valid));

   p_frame_hold_r8: assert property (@(posedge clk) disable iff (!cfg_rst_n)
      (tx_grant && tx_frame_active && tx_rst_n) |=> (tx_grant || !tx_frame_active));

endmodule

bind ptp_ready_ctrl ptp_ready_ctrl_sva u_sva (
   .clk             (clk),
   .tx_rst_n        (tx_rst_n),
   .rx_rst_n        (rx_rst_n),
   .cfg_rst_n       (cfg_rst_n),
   .link_up         (link_up),
   .tod_major       (tod_major),
   .tx_frame_active (tx_frame_active),
   .tx_ready        (tx_ready),
   .rx_ready        (rx_ready),
   .tx_grant        (tx_grant),
   .rx_ts_valid     (rx_ts_valid)
);

// File: tb/ptp_ready_ctrl_tb.sv
`timescale 1ns/1ps
module ptp_ready_ctrl_tb;
   localparam int TP = 5;
   localparam int AC = 8;
   localparam int GA = 2;
   localparam int GUARD_LEN = GA * AC;

   logic clk = 1'b0;
   logic tx_rst_n = 1'b0, rx_rst_n = 1'b0, cfg_rst_n = 1'b0;
   logic link_up = 1'b0, rx_pkt = 1'b0, tod_major = 1'b0, tx_frame_active = 1'b0;
   logic tx_ready, rx_ready, tx_grant, rx_ts_valid;

   int vectors = 0;
   int miscompares = 0;
   bit started = 1'b0;
   bit finished = 1'b0;

   // behavioural reference state
   bit m_txr = 0, m_rxr = 0, m_desk = 0, m_fly = 0;
   int m_train = 0;
   int m_guard = 0;

   always #2.5 clk = ~clk;

   ptp_ready_ctrl #(.TRAIN_PKTS(TP), .AM_CYCLES(AC), .GUARD_AMS(GA)) u_dut (
      .clk(clk), .tx_rst_n(tx_rst_n), .rx_rst_n(rx_rst_n), .cfg_rst_n(cfg_rst_n),
      .link_up(link_up), .rx_pkt(rx_pkt), .tod_major(tod_major),
      .tx_frame_active(tx_frame_active), .tx_ready(tx_ready), .rx_ready(rx_ready),
      .tx_grant(tx_grant), .rx_ts_valid(rx_ts_valid));

   function automatic bit m_grant();
      return m_txr && (m_guard == 0 || m_fly);
   endfunction

   always @(posedge clk) begin
      automatic bit g = m_grant();
      automatic bit txs = tx_rst_n && cfg_rst_n;
      if (!cfg_rst_n || !rx_rst_n || !link_up) begin
         m_desk = 0;
         m_train = 0;
      end else if (rx_pkt && tx_rst_n && !m_desk) begin
         m_train++;
         if (m_train >= TP) m_desk = 1;
      end
      m_rxr = txs && rx_rst_n && link_up && m_desk;
      m_txr = txs;
      if (!txs || tod_major) m_guard = GUARD_LEN;
      else if (m_guard > 0) m_guard--;
      m_fly = txs && tx_frame_active && g;
      started = 1'b1;
   end

   task automatic cmp(string tag, logic act, bit exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (started && !finished) begin
         cmp("R1 tx_ready model", tx_ready, m_txr);
         cmp("R3 rx_ready model", rx_ready, m_rxr);
         cmp("R7 tx_grant model", tx_grant, m_grant());
         cmp("R9 rx_ts_valid model", rx_ts_valid, m_rxr && m_guard == 0);
      end
   end

   task automatic cyc(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pkts(int n);
      for (int i = 0; i < n; i++) begin
         rx_pkt = 1'b1;
         cyc(1);
         rx_pkt = 1'b0;
         cyc(1);
      end
   endtask

   initial begin
      cyc(3);
      cmp("R1 reset tx_ready", tx_ready, 0);
      cmp("R2 reset rx_ready", rx_ready, 0);
      cmp("R7 reset tx_grant", tx_grant, 0);
      cmp("R9 reset rx_ts_valid", rx_ts_valid, 0);

      cfg_rst_n = 1; tx_rst_n = 1; rx_rst_n = 1; link_up = 1;
      cyc(1);
      cmp("R1 tx_ready after release", tx_ready, 1);
      cmp("R6 grant blocked in guard", tx_grant, 0);
      pkts(TP - 1);
      cmp("R3 not ready below threshold", rx_ready, 0);
      rx_pkt = 1; cyc(1); rx_pkt = 0;
      cmp("R3 ready at threshold", rx_ready, 1);
      cmp("R6 ts invalid in guard", rx_ts_valid, 0);
      cyc(GUARD_LEN);
      cmp("R7 grant after guard", tx_grant, 1);
      cmp("R9 ts valid after guard", rx_ts_valid, 1);

      // RX reset alone
      rx_rst_n = 0; cyc(1); rx_rst_n = 1;
      cmp("R2 rx reset drops rx_ready", rx_ready, 0);
      cmp("R1 rx reset keeps tx_ready", tx_ready, 1);
      cmp("R1 rx reset keeps grant", tx_grant, 1);
      cyc(2);
      cmp("R3 retrain needed after rx reset", rx_ready, 0);
      pkts(TP);
      cmp("R3 ready after retrain", rx_ready, 1);

      // TX reset alone
      tx_rst_n = 0; cyc(2);
      cmp("R1 tx reset drops tx_ready", tx_ready, 0);
      cmp("R2 tx reset drops rx_ready", rx_ready, 0);
      tx_rst_n = 1; cyc(1);
      cmp("R4 rx_ready back without training", rx_ready, 1);
      cmp("R6 guard after tx reset", tx_grant, 0);
      cyc(GUARD_LEN);
      cmp("R7 grant after tx reset guard", tx_grant, 1);

      // tod update with a frame in flight
      tx_frame_active = 1; cyc(1);
      tod_major = 1; cyc(1); tod_major = 0;
      cmp("R8 frame keeps grant", tx_grant, 1);
      cmp("R6 ts invalid after tod", rx_ts_valid, 0);
      cyc(3);
      cmp("R8 frame still granted", tx_grant, 1);
      tx_frame_active = 0; cyc(1);
      cmp("R8 grant ends with frame", tx_grant, 0);
      tx_frame_active = 1; cyc(2);
      cmp("R8 frame started in guard not granted", tx_grant, 0);
      tx_frame_active = 0;
      cyc(GUARD_LEN);
      cmp("R7 grant after tod guard", tx_grant, 1);

      // tod update while idle: exact window length
      tod_major = 1; cyc(1); tod_major = 0;
      cmp("R6 idle tod blocks grant", tx_grant, 0);
      cyc(GUARD_LEN - 1);
      cmp("R6 last guard cycle", tx_grant, 0);
      cyc(1);
      cmp("R6 guard expires", tx_grant, 1);

      // link drop
      link_up = 0; cyc(1);
      cmp("R5 link down drops rx_ready", rx_ready, 0);
      pkts(2);
      link_up = 1; cyc(1);
      cmp("R5 still not ready on link up", rx_ready, 0);
      pkts(TP - 1);
      cmp("R5 link-down packets not counted", rx_ready, 0);
      pkts(1);
      cmp("R5 ready after fresh training", rx_ready, 1);

      // configuration reset clears everything
      cfg_rst_n = 0; cyc(1); cfg_rst_n = 1; cyc(1);
      cmp("R2 cfg reset then retrain", rx_ready, 0);
      cmp("R1 tx_ready after cfg reset", tx_ready, 1);
      cyc(3);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(TP * 0 + 200000 * 5);
      if (!finished) begin
         finished = 1'b1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule